// File: doc/BRIEF.md
# Systolic Matrix-Vector Multiplier

This block multiplies a square matrix by a vector. It uses a linear chain of identical multiply-accumulate cells, with registered links between neighbouring cells. The caller presents one whole matrix row per clock on a wide input. Skew registers inside the block then delay column j by j cycles. Each cell therefore receives its matrix element one cycle after its left neighbour. The matrix reaches the array as anti-diagonals: element (1,1) first, then (2,1) with (1,2), then (3,1), (2,2) and (1,3), and so on.

Cell j holds vector element x_j. A partial sum for a row enters the chain at the first cell as zero. At each cell it gains the product of that cell's matrix element and vector element, and it is then passed to the right. The finished result leaves the last cell into an output register. Consecutive rows therefore produce results on consecutive cycles, in the order the rows were accepted.

A new vector is loaded together with a row and travels through the same skew registers as that row. Each cell latches its new element exactly when the first row that needs it arrives. Rows still in flight finish with the old vector, so a new matrix and vector can follow the previous ones with no gap. Cycles with no row are bubbles. A valid bit travels with every element and every partial sum, and a bubble never adds anything to a result.

Top module: `mv_systolic`

## Requirements
- R1: After a synchronous active-low reset, `y_vld` is 0, `y_data` is 0, and every stored vector element is 0. A row accepted before any vector load therefore yields a result of 0.
- R2: Element j of a row sits at bits [j*DW +: DW] of `row_data`, and element j of the vector at the same bits of `vec_data`. Both are signed two's complement. Each result equals the sum over j of row[j]*vec[j], exact in AW bits (34 by default), including for operands of -32768.
- R3: A row accepted on rising edge k produces its result with `y_vld` high for exactly one cycle after edge k+N. Results appear in acceptance order, and a row is accepted in every cycle that `row_vld` is high.
- R4: A cycle with `row_vld` low is a bubble. It produces no `y_vld` pulse and does not change the results of the neighbouring rows. `y_data` is 0 whenever `y_vld` is 0.
- R5: When `vec_ld` is high, `vec_data` becomes the vector for the row accepted in the same cycle and for all later rows. Rows accepted earlier use the previous vector, even though they are still inside the array.
- R6: Matrices can follow each other with no idle cycle between the last row of one and the first row of the next, each with its own vector. All results remain correct.
- R7: A vector load in a bubble cycle takes effect for the following rows and produces no result.
- R8: A loaded vector stays in force for any number of later rows until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| row_vld | input | 1 | A matrix row is presented this cycle |
| row_data | input | N*DW | Row elements, element j at bits [j*DW +: DW], signed |
| vec_ld | input | 1 | Replace the vector, starting with this cycle's row |
| vec_data | input | N*DW | Vector elements, element j at bits [j*DW +: DW], signed |
| y_vld | output | 1 | `y_data` carries a finished result |
| y_data | output | AW | Result element, signed, 0 when `y_vld` is low |

## Verification
The hardest case to reach from the ports is a vector change while rows of the previous matrix are still partway through the chain. In that case the right-hand cells must still apply the old vector elements while the left-hand cells already apply the new ones. The stimulus reaches it by streaming matrices back to back, each with a fresh vector loaded on its first row. It also mixes in loads during bubble cycles and random gaps between rows. Every result is checked against a sum computed in the bench from the vector that was current when that row was accepted.

// File: rtl/mv_pkg.sv
// mv_pkg: shared defaults and width helper for the systolic matrix-vector block.
// Assumes: callers pass a positive order and operand width.
package mv_pkg;

    parameter int ORDER_DEF  = 4;
    parameter int DATA_W_DEF = 16;

    // Accumulator width: full product plus enough headroom for N additions,
    // with at least one guard bit so the extension field is never empty.
    function automatic int acc_w(input int order, input int dw);
        int grow;
        grow = $clog2(order);
        if (grow < 1) grow = 1;
        return 2 * dw + grow;
    endfunction

endpackage

// File: rtl/mv_skew.sv
// mv_skew: fixed-length delay line for one input lane of the array.
// Each lane is delayed by its column index so that the matrix reaches the
// cells one anti-diagonal per clock.
// Assumes: DEPTH >= 0; a depth of 0 is a plain wire.
module mv_skew #(
    parameter int W     = 8,
    parameter int DEPTH = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_thru
            logic unused_pins;
            assign unused_pins = clk ^ rst_n;
            assign q = d;
        end else begin : g_dly
            logic [W-1:0] stage [DEPTH];

            // Shift the lane one stage per clock; reset clears every stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
                end else begin
                    stage[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
                end
            end

            assign q = stage[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/mv_cell.sv
// mv_cell: one multiply-accumulate stage of the chain.
// Holds one vector element. When the arriving matrix element is valid, the cell
// adds element*vector to the incoming partial sum and registers the result
// for the next cell; a bubble registers zero with valid low.
// Assumes: AW > 2*DW; the matrix element and the partial sum of the same row
// arrive in the same cycle.
module mv_cell #(
    parameter int DW = 16,
    parameter int AW = 34
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] a_in,
    input  logic                 a_vld,
    input  logic signed [DW-1:0] x_in,
    input  logic                 x_ld,
    input  logic signed [AW-1:0] sum_in,
    input  logic                 sum_vld_in,
    output logic signed [AW-1:0] sum_out,
    output logic                 sum_vld_out
);

    localparam int PW  = 2 * DW;
    localparam int EXT = AW - PW;

    logic signed [DW-1:0] x_q;
    logic signed [DW-1:0] x_use;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;
    logic signed [AW-1:0] sum_d;

    // Pick the vector element: a load arriving with this element applies at once.
    always_comb x_use = x_ld ? x_in : x_q;

    // Form the product and the next partial sum; a bubble gives zero.
    always_comb begin
        prod     = a_in * x_use;
        prod_ext = {{EXT{prod[PW-1]}}, prod};
        sum_d    = a_vld ? (sum_in + prod_ext) : '0;
    end

    // Keep the vector element until the next load.
    always_ff @(posedge clk) begin
        if (!rst_n)    x_q <= '0;
        else if (x_ld) x_q <= x_in;
    end

    // Register the partial sum and its valid bit towards the next cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_out     <= '0;
            sum_vld_out <= 1'b0;
        end else begin
            sum_out     <= sum_d;
            sum_vld_out <= a_vld;
        end
    end

    // R4: the skewed element and the partial sum of its row always line up
    // (a valid sum never meets a bubble, and the reverse).
    bubble_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_vld == sum_vld_in);

endmodule

// File: rtl/mv_systolic.sv
// mv_systolic: N-cell systolic matrix-vector multiplier.
// Accepts one matrix row per clock and skews it column by column into a chain
// of multiply-accumulate cells. Partial sums flow left to right, and each
// finished result is registered at the chain's right end.
// Vector loads ride the same skew as the row, so a new vector applies from
// its row on without disturbing rows already in flight.
// Assumes: N >= 1, AW > 2*DW.
module mv_systolic #(
    parameter int N  = mv_pkg::ORDER_DEF,
    parameter int DW = mv_pkg::DATA_W_DEF,
    parameter int AW = mv_pkg::acc_w(N, DW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 row_vld,
    input  logic [N*DW-1:0]      row_data,
    input  logic                 vec_ld,
    input  logic [N*DW-1:0]      vec_data,
    output logic                 y_vld,
    output logic signed [AW-1:0] y_data
);

    // Lane layout: {x_ld, x, a_vld, a}
    localparam int LW    = 2 * DW + 2;
    localparam int A_LO  = 0;
    localparam int AV_B  = DW;
    localparam int X_LO  = DW + 1;
    localparam int XL_B  = 2 * DW + 1;
    localparam int FW    = $clog2(N + 2) + 1;

    logic [LW-1:0]        lane_in  [N];
    logic [LW-1:0]        lane_out [N];
    logic signed [DW-1:0] a_l [N];
    logic signed [DW-1:0] x_l [N];
    logic                 a_v [N];
    logic                 x_v [N];
    logic signed [AW-1:0] sum_c [N+1];
    logic                 vld_c [N+1];

    assign sum_c[0] = '0;
    assign vld_c[0] = row_vld;

    generate
        for (genvar j = 0; j < N; j++) begin : g_col
            // Bundle column j of the row with the matching vector element.
            assign lane_in[j] = {vec_ld, vec_data[j*DW +: DW],
                                 row_vld, row_data[j*DW +: DW]};

            mv_skew #(.W(LW), .DEPTH(j)) skew_i (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (lane_in[j]),
                .q     (lane_out[j])
            );

            assign a_l[j] = lane_out[j][A_LO +: DW];
            assign a_v[j] = lane_out[j][AV_B];
            assign x_l[j] = lane_out[j][X_LO +: DW];
            assign x_v[j] = lane_out[j][XL_B];

            mv_cell #(.DW(DW), .AW(AW)) cell_i (
                .clk         (clk),
                .rst_n       (rst_n),
                .a_in        (a_l[j]),
                .a_vld       (a_v[j]),
                .x_in        (x_l[j]),
                .x_ld        (x_v[j]),
                .sum_in      (sum_c[j]),
                .sum_vld_in  (vld_c[j]),
                .sum_out     (sum_c[j+1]),
                .sum_vld_out (vld_c[j+1])
            );

            if (j > 0) begin : g_align
                // R3: each lane's element trails its left neighbour by one cycle.
                lane_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    a_v[j] |-> $past(a_v[j-1]));
                // R5: a vector load reaches each cell one cycle after the cell to its left.
                vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    x_v[j] |-> $past(x_v[j-1]));
            end
        end
    endgenerate

    // Register the finished sum at the array boundary; idle cycles show zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_vld  <= 1'b0;
            y_data <= '0;
        end else begin
            y_vld  <= vld_c[N];
            y_data <= vld_c[N] ? sum_c[N] : '0;
        end
    end

    // Track rows accepted but not yet delivered, for the checks below.
    logic [FW-1:0] in_flight;
    always_ff @(posedge clk) begin
        if (!rst_n) in_flight <= '0;
        else if (row_vld && !y_vld) in_flight <= in_flight + 1'b1;
        else if (!row_vld && y_vld) in_flight <= in_flight - 1'b1;
    end

    // R4: a result never appears without an accepted row behind it.
    out_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_vld |-> (in_flight != '0));

    // R3: no more rows are ever pending than the pipeline depth allows.
    flight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight <= FW'(N + 1));

    // R4: the output is zero whenever no result is flagged.
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !y_vld |-> (y_data == '0));

endmodule

// File: tb/mv_systolic_tb_top.sv
// Bench for mv_systolic: streams matrices and vectors with gaps and loads,
// and compares every result with a sum computed here.
module mv_systolic_tb_top;

    localparam int N      = 4;
    localparam int DW     = 16;
    localparam int AW     = 34;
    localparam int CLK_PS = 10;
    localparam int QMAX   = 8192;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 row_vld;
    logic [N*DW-1:0]      row_data;
    logic                 vec_ld;
    logic [N*DW-1:0]      vec_data;
    logic                 y_vld;
    logic signed [AW-1:0] y_data;

    always #(CLK_PS/2) clk = ~clk;

    mv_systolic #(.N(N), .DW(DW), .AW(AW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_vld  (row_vld),
        .row_data (row_data),
        .vec_ld   (vec_ld),
        .vec_data (vec_data),
        .y_vld    (y_vld),
        .y_data   (y_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    logic signed [AW-1:0] exp_val [QMAX];
    int                   exp_cyc [QMAX];
    string                exp_tag [QMAX];
    int push_n = 0;
    int pop_n  = 0;

    logic signed [DW-1:0] row_m [N];
    logic signed [DW-1:0] vec_n [N];
    logic signed [DW-1:0] cur_v [N];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // Output monitor: compare each result in order, and require zero when idle.
    always @(negedge clk) begin
        if (mon_en) begin
            if (y_vld) begin
                if (pop_n < push_n) begin
                    check(y_data == exp_val[pop_n], exp_tag[pop_n], y_data, exp_val[pop_n]);
                    check(cyc == exp_cyc[pop_n], "R3 timing", cyc, exp_cyc[pop_n]);
                    pop_n++;
                end else begin
                    check(1'b0, "R4 extra result", 1, 0);
                end
            end else begin
                check(y_data == '0, "R4 idle output", y_data, 0);
                if (pop_n < push_n && exp_cyc[pop_n] == cyc)
                    check(1'b0, "R3 missing result", 0, 1);
            end
        end
    end

    // Present one cycle of stimulus and record the expected result.
    task automatic drive(input bit rv, input bit vl, input string tag);
        logic signed [AW-1:0] acc;
        row_vld = rv;
        vec_ld  = vl;
        for (int j = 0; j < N; j++) begin
            row_data[j*DW +: DW] = row_m[j];
            vec_data[j*DW +: DW] = vec_n[j];
        end
        if (vl) for (int j = 0; j < N; j++) cur_v[j] = vec_n[j];
        if (rv) begin
            acc = '0;
            for (int j = 0; j < N; j++) acc = acc + row_m[j] * cur_v[j];
            exp_val[push_n] = acc;
            exp_cyc[push_n] = cyc + 1 + N;
            exp_tag[push_n] = tag;
            push_n++;
        end
        @(negedge clk);
    endtask

    task automatic rand_row();
        for (int j = 0; j < N; j++) row_m[j] = DW'($urandom);
    endtask

    task automatic rand_vec();
        for (int j = 0; j < N; j++) vec_n[j] = DW'($urandom);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) drive(1'b0, 1'b0, "idle");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        row_vld  = 1'b0;
        vec_ld   = 1'b0;
        row_data = '1;
        vec_data = '1;
        for (int j = 0; j < N; j++) begin
            row_m[j] = '0;
            vec_n[j] = '0;
            cur_v[j] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs are cleared after reset.
        check(y_vld == 1'b0, "R1 reset y_vld", y_vld, 0);
        check(y_data == '0, "R1 reset y_data", y_data, 0);
        mon_en = 1'b1;

        // R1: no vector loaded yet, so a nonzero row gives zero.
        for (int j = 0; j < N; j++) row_m[j] = DW'(j + 7);
        drive(1'b1, 1'b0, "R1 cleared vector");
        idle(N + 2);

        // R2: extreme operands in every lane.
        for (int j = 0; j < N; j++) begin row_m[j] = -16'sd32768; vec_n[j] = -16'sd32768; end
        drive(1'b1, 1'b1, "R2 min*min");
        for (int j = 0; j < N; j++) row_m[j] = 16'sd32767;
        drive(1'b1, 1'b0, "R2 max*min");
        for (int j = 0; j < N; j++) vec_n[j] = 16'sd32767;
        drive(1'b1, 1'b1, "R2 max*max");
        idle(N + 2);

        // R2: unit vectors pick out single columns.
        for (int k = 0; k < N; k++) begin
            for (int j = 0; j < N; j++) vec_n[j] = (j == k) ? 16'sd1 : 16'sd0;
            rand_row();
            drive(1'b1, 1'b1, "R2 column select");
        end
        idle(N + 2);

        // R5, R6: back-to-back matrices, each loading its vector on the first row.
        for (int m = 0; m < 400; m++) begin
            rand_vec();
            rand_row();
            drive(1'b1, 1'b1, "R5 load with row");
            for (int r = 1; r < N; r++) begin
                rand_row();
                drive(1'b1, 1'b0, "R6 back-to-back");
            end
        end
        idle(N + 2);

        // R4, R7: random bubbles, loads in bubble cycles, loads with rows.
        for (int i = 0; i < 3000; i++) begin
            bit rv, vl;
            rv = ($urandom % 3) != 0;
            vl = ($urandom % 5) == 0;
            rand_row();
            if (vl) rand_vec();
            if (!rv) drive(1'b0, vl, "R7 bubble load");
            else     drive(1'b1, vl, vl ? "R5 load with row" : "R4 around bubbles");
        end
        idle(N + 2);

        // R7: a vector loaded during a bubble, then used by the next rows.
        rand_vec();
        drive(1'b0, 1'b1, "R7 bubble load");
        rand_row();
        drive(1'b1, 1'b0, "R7 after bubble load");
        idle(N + 2);

        // R8: one load, then many rows without a new load.
        rand_vec();
        rand_row();
        drive(1'b1, 1'b1, "R8 persistent vector");
        for (int i = 0; i < 40; i++) begin
            rand_row();
            drive(i % 7 != 3, 1'b0, "R8 persistent vector");
        end
        idle(N + 3);

        // R3: every accepted row produced exactly one result.
        check(pop_n == push_n, "R3 result count", pop_n, push_n);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule